// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counter Timer Group

The block holds four periodic down-counting timers behind one shared control register. Each timer has a base register and a count register. Clearing the inhibit bit in the base register starts the timer. The timer then counts down once per prescaled tick and reloads from its base when it runs out. It raises an active-low level interrupt on every run-out, and it repeats until software sets the inhibit bit again. A shared prescaler divides the input clock by 8, 16, 32 or 64 before the timers see it.

Neighbouring timers can be chained through the control register. Timer k becomes the low half of a pair and timer k+1 the high half. The low half counts with its full 32 bits and its interrupt is masked. Its start and stop follow the high half. If the linking bit for the pair is also set, the high half steps once each time the low half reloads. This makes one long counter whose interrupt comes from the high timer.

Software reaches every register through a single-cycle write strobe with an address, and reads through a combinational read-data port. A status register collects pending interrupts and clears them when a one is written.

Top module: `tmr_group`

## Requirements
- R1: After reset every base register reads 0x8000_0000 (inhibited), every count register reads 0, the control register reads 0 (divide by 8, no chaining), the status register reads 0 and all four bits of `irq_n` are 1.
- R2: While a timer is not running, its count register holds its value and its interrupt does not assert. An unchained timer is not running while bit 31 of its base register is set.
- R3: When a timer starts, its count loads base bits 30:0. On each prescaled tick the count decrements. A tick while the count is zero reloads the count and sets the timer's pending flag, so an unchained timer with base B fires every (B+1) ticks.
- R4: Control bits 9:8 select the prescaler: 00 gives one tick per 8 clocks, 01 per 16, 10 per 32 and 11 per 64.
- R5: Count register bit 31 of an unchained timer reads a toggle flag that inverts on every reload. Bits 30:0 read the remaining count.
- R6: `irq_n[i]` is low exactly while pending flag i is set. The flag stays set until a write to the status register (address 9) with a one in bit i. Writing zero bits has no effect. The status register reads the pending flags in bits 3:0.
- R7: A running timer keeps firing periodically. Setting its inhibit bit stops it and clears its count register to 0 on the next clock edge.
- R8: A write to count register i (address 2i+1) loads the written value, so a write of zero clears it. Base register i sits at address 2i and the control register at address 8.
- R9: With control bit k (k=0..2) set, timer k follows the run state of timer k+1. It reloads from all 32 bits of its base, its count register reads all 32 count bits, and its interrupt stays deasserted. Stopping the high timer clears both counts.
- R10: With control bits k and 24+k both set, timer k+1 steps once per reload of timer k instead of per tick. Lower base L and upper base U then give an upper interrupt every (U+1)(L+1) ticks.
- R11: With control bit k set and bit 24+k clear, timer k+1 still steps on every prescaled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_n | output | 4 | Active-low level interrupt per timer |

## Verification
A fault in the prescaler or in a counter shows up as a wrong interval between two interrupts of the same timer. That interval is known exactly from the base value and the divider, so the error appears within one period, at most a few hundred clocks in these tests. A wrong run or chaining state shows up one edge after the write that caused it. Either a count register fails to reload or clear, or a masked low timer pulls its interrupt line. A lost or stuck pending flag is visible on `irq_n` in the same cycle as the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_TMR = 4;
  localparam int CNT_W = 32;

  // Prescaler terminal value for a divider select (8 << sel) - 1
  function automatic logic [5:0] div_limit(input logic [1:0] sel);
    logic [6:0] d;
    d = 7'd8 << sel;
    return 6'(d - 7'd1);
  endfunction

  // Reload value: chained low halves use all bits, others drop the inhibit bit
  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] base,
                                                  input logic full);
    return full ? base : {1'b0, base[CNT_W-2:0]};
  endfunction

  // Run state, resolved from the top timer downward through chain bits
  function automatic logic [N_TMR-1:0] chain_run(input logic [N_TMR-2:0] casc,
                                                 input logic [N_TMR-1:0] inh);
    logic [N_TMR-1:0] r;
    r[N_TMR-1] = ~inh[N_TMR-1];
    for (int i = N_TMR - 2; i >= 0; i--)
      r[i] = casc[i] ? r[i+1] : ~inh[i];
    return r;
  endfunction

  // Step enables, resolved from timer 0 upward through link bits
  function automatic logic [N_TMR-1:0] chain_step(input logic [N_TMR-1:0] run,
                                                  input logic [N_TMR-1:0] zero,
                                                  input logic [N_TMR-2:0] link,
                                                  input logic tick);
    logic [N_TMR-1:0] s;
    s[0] = run[0] & tick;
    for (int i = 1; i < N_TMR; i++)
      s[i] = run[i] & (link[i-1] ? (s[i-1] & zero[i-1]) : tick);
    return s;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = PRE_W'(div_limit(sel));
  assign tick = (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         full,
  input  logic [W-1:0] base,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         tog,
  output logic         zero
);
  logic         run_q;
  logic [W-1:0] rld;
  logic         start_ev;
  logic         stop_ev;

  assign rld      = reload_val(base, full);
  assign start_ev = run & ~run_q;
  assign stop_ev  = ~run & run_q;
  assign zero     = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
      tog   <= 1'b0;
    end else begin
      run_q <= run;
      if (wr) begin
        cnt <= full ? wdata : {1'b0, wdata[W-2:0]};
        tog <= 1'b0;
      end else if (start_ev) begin
        cnt <= rld;
      end else if (stop_ev) begin
        cnt <= '0;
      end else if (step) begin
        if (zero) begin
          cnt <= rld;
          tog <= ~tog;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_TMR-1:0]  irq_n
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * N_TMR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * N_TMR + 1);
  localparam int ROVR_LSB = 24;
  localparam int SEL_LSB  = 8;

  logic [N_TMR-1:0][CNT_W-1:0] base_q;
  logic [N_TMR-2:0]            casc_q;
  logic [N_TMR-2:0]            rovr_q;
  logic [1:0]                  sel_q;
  logic [N_TMR-1:0]            pend_q;

  logic                        tick;
  logic [N_TMR-1:0]            inh;
  logic [N_TMR-1:0]            run;
  logic [N_TMR-1:0]            step;
  logic [N_TMR-1:0]            zero;
  logic [N_TMR-1:0]            expire;
  logic [N_TMR-1:0]            full;
  logic [N_TMR-1:0]            wr_cnt;
  logic [N_TMR-1:0]            tog;
  logic [N_TMR-1:0]            ack;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_v;
  logic [N_TMR-2:0]            link;

  tmr_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel_q),
    .tick (tick)
  );

  assign link   = casc_q & rovr_q;
  assign run    = chain_run(casc_q, inh);
  assign step   = chain_step(run, zero, link, tick);
  assign expire = step & zero;
  assign ack    = (bus_wr && bus_addr == A_STAT) ? bus_wdata[N_TMR-1:0] : '0;

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_tmr
      assign inh[gi]    = base_q[gi][CNT_W-1];
      assign wr_cnt[gi] = bus_wr && (bus_addr == ADDR_W'(2 * gi + 1));
      if (gi < N_TMR - 1) begin : g_low
        assign full[gi] = casc_q[gi];
      end else begin : g_top
        assign full[gi] = 1'b0;
      end

      tmr_channel u_ch (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run[gi]),
        .step (step[gi]),
        .full (full[gi]),
        .base (base_q[gi]),
        .wr   (wr_cnt[gi]),
        .wdata(bus_wdata),
        .cnt  (cnt_v[gi]),
        .tog  (tog[gi]),
        .zero (zero[gi])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          base_q[gi] <= {1'b1, {(CNT_W-1){1'b0}}};
        else if (bus_wr && bus_addr == ADDR_W'(2 * gi))
          base_q[gi] <= bus_wdata;
      end
    end
  endgenerate

  // Shared control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_q <= '0;
      rovr_q <= '0;
      sel_q  <= 2'b00;
    end else if (bus_wr && bus_addr == A_CTRL) begin
      casc_q <= bus_wdata[N_TMR-2:0];
      rovr_q <= bus_wdata[ROVR_LSB +: N_TMR-1];
      sel_q  <= bus_wdata[SEL_LSB +: 2];
    end
  end

  // Pending flags: a masked low half never sets; a new expiry beats an ack
  logic [N_TMR-1:0] masked;
  assign masked = {1'b0, casc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack) | (expire & ~masked);
  end

  assign irq_n = ~pend_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[N_TMR-2:0]           = casc_q;
      bus_rdata[ROVR_LSB +: N_TMR-1] = rovr_q;
      bus_rdata[SEL_LSB +: 2]        = sel_q;
    end else if (bus_addr == A_STAT) begin
      bus_rdata[N_TMR-1:0] = pend_q;
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (bus_addr == ADDR_W'(2 * i))
          bus_rdata = base_q[i];
        else if (bus_addr == ADDR_W'(2 * i + 1))
          bus_rdata = full[i] ? cnt_v[i] : {tog[i], cnt_v[i][CNT_W-2:0]};
      end
    end
  end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk
  import tmr_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic [N_TMR-1:0]            run,
  input logic [N_TMR-1:0]            step,
  input logic [N_TMR-1:0]            zero,
  input logic [N_TMR-1:0]            wr_cnt,
  input logic [N_TMR-1:0]            ack,
  input logic [N_TMR-2:0]            casc_q,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt_v,
  input logic [N_TMR-1:0]            irq_n
);
  logic [N_TMR-1:0] hold;
  assign hold = ~irq_n & ~ack;

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~irq_n & $past(hold)) == $past(hold)));

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_c
      // R3
      decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step[gi] && $past(run[gi]) && !zero[gi] && !wr_cnt[gi])
        |=> cnt_v[gi] == $past(cnt_v[gi]) - 1);

      // R2
      idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[gi] && $past(!run[gi]) && !wr_cnt[gi]) |=> $stable(cnt_v[gi]));

      // R7
      stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run[gi]) && !wr_cnt[gi]) |=> cnt_v[gi] == '0);

      if (gi < N_TMR - 1) begin : g_m
        // R9
        low_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (casc_q[gi] && irq_n[gi]) |=> irq_n[gi]);
      end
    end
  endgenerate
endmodule

bind tmr_group tmr_group_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .run   (run),
  .step  (step),
  .zero  (zero),
  .wr_cnt(wr_cnt),
  .ack   (ack),
  .casc_q(casc_q),
  .cnt_v (cnt_v),
  .irq_n (irq_n)
);

// File: tb/sim_tmr_group.sv
module sim_tmr_group;
  localparam int CLK_P = 10;
  localparam int WAIT_MAX = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [3:0] seen_low;

  tmr_group u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(CLK_P * 150000);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      seen_low = seen_low | ~irq_n;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_low(input int i, output int t);
    t = -1;
    for (int k = 0; k < WAIT_MAX; k++) begin
      @(negedge clk);
      seen_low = seen_low | (~irq_n & ~(4'b1 << i));
      if (!irq_n[i]) begin
        t = cyc;
        break;
      end
    end
  endtask

  // Interval between two consecutive interrupts of timer i
  task automatic period(input int i, output int p);
    int t1, t2;
    wait_low(i, t1);
    wr(4'd9, 32'(1) << i);
    wait_low(i, t2);
    wr(4'd9, 32'(1) << i);
    p = (t1 < 0 || t2 < 0) ? -1 : t2 - t1;
  endtask

  function automatic int exp_period(input int b, input int sel);
    return (b + 1) * (8 << sel);
  endfunction

  task automatic stop_all();
    for (int i = 0; i < 4; i++) wr(4'(2 * i), 32'h8000_0000);
    wr(4'd8, 32'h0);
    wr(4'd9, 32'hF);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_n", {28'b0, irq_n}, 32'hF);
    rd(4'd8, d); chk("R1 ctrl", d, 32'h0);
    rd(4'd9, d); chk("R1 status", d, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(4'(2 * i), d);     chk("R1 base", d, 32'h8000_0000);
      rd(4'(2 * i + 1), d); chk("R1 count", d, 32'h0);
    end
  endtask

  task automatic t_inhibit();
    logic [31:0] d;
    seen_low = '0;
    idle(100);
    rd(4'd1, d); chk("R2 count idle", d, 32'h0);
    wr(4'd1, 32'h5);
    idle(1);
    rd(4'd1, d); chk("R8 count write", d, 32'h5);
    idle(60);
    rd(4'd1, d); chk("R2 count held", d, 32'h5);
    chk("R2 no irq", {28'b0, seen_low}, 32'h0);
    wr(4'd1, 32'h0);
    idle(1);
    rd(4'd1, d); chk("R8 zero clears", d, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d, a, b;
    int p, t;
    wr(4'd0, 32'd4);
    idle(1);
    rd(4'd1, d); chk("R3 start load", {31'b0, (d[30:0] <= 31'd4)}, 32'h1);
    period(0, p); chk("R3 period", 32'(p), 32'(exp_period(4, 0)));
    period(0, p); chk("R7 still periodic", 32'(p), 32'(exp_period(4, 0)));
    wait_low(0, t);
    rd(4'd1, a);
    wr(4'd9, 32'h1);
    wait_low(0, t);
    rd(4'd1, b);
    chk("R5 toggle flips", {31'b0, a[31] ^ b[31]}, 32'h1);
    // leave the flag set with the timer stopped
    wr(4'd0, 32'h8000_0004);
    idle(1);
    rd(4'd1, d); chk("R7 stop clears", d, 32'h0);
    idle(100);
    chk("R6 level held", {31'b0, irq_n[0]}, 32'h0);
    rd(4'd9, d); chk("R6 status", d, 32'h1);
    wr(4'd9, 32'h2);
    chk("R6 other ack no effect", {31'b0, irq_n[0]}, 32'h0);
    wr(4'd9, 32'h1);
    chk("R6 ack clears", {31'b0, irq_n[0]}, 32'h1);
  endtask

  task automatic t_div();
    int p;
    wr(4'd8, 32'h300);
    wr(4'd4, 32'd1);
    period(2, p); chk("R4 div64", 32'(p), 32'(exp_period(1, 3)));
    stop_all();
    wr(4'd8, 32'h100);
    wr(4'd4, 32'd1);
    period(2, p); chk("R4 div16", 32'(p), 32'(exp_period(1, 1)));
    stop_all();
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    int p;
    seen_low = '0;
    wr(4'd8, 32'h0100_0001);
    wr(4'd0, 32'd3);
    wr(4'd2, 32'd2);
    period(1, p); chk("R10 chained period", 32'(p), 32'(3 * 4 * 8));
    chk("R9 low irq masked", {31'b0, seen_low[0]}, 32'h0);
    wr(4'd2, 32'h8000_0002);
    idle(1);
    rd(4'd1, d); chk("R9 stop clears low", d, 32'h0);
    rd(4'd3, d); chk("R9 stop clears high", d, 32'h0);
    wr(4'd0, 32'h8000_0005);
    wr(4'd2, 32'd2);
    idle(1);
    rd(4'd1, d);
    chk("R9 full width low", {31'b0, (d >= 32'h8000_0000 && d <= 32'h8000_0005)}, 32'h1);
    stop_all();
    seen_low = '0;
    wr(4'd8, 32'h1);
    wr(4'd0, 32'd3);
    wr(4'd2, 32'd2);
    period(1, p); chk("R11 unlinked period", 32'(p), 32'(exp_period(2, 0)));
    chk("R11 low still masked", {31'b0, seen_low[0]}, 32'h0);
    stop_all();
  endtask

  initial begin
    seen_low = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_inhibit();
    t_basic();
    t_div();
    t_cascade();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule